// File: doc/BRIEF.md
# Palette Entry Format Converter

This block fills a colour lookup table for indexed-colour display modes. A load begins with a one-cycle `load_start` pulse. The pixel-depth code, the 2-bit entry format and the monochrome flag are captured on that edge. The depth code sets how many raw 32-bit words the block then takes from the `ent_valid`/`ent_data` stream. Each accepted word is decoded into a 25-bit result, made of a transparency flag and 8-bit red, green and blue, and written to the next slot of a 256-slot table. The raw word is kept beside it.

Lookups are served by index with one cycle of latency. A slot that has not been written since the last load returns zero.

When a frame starts (`frame_start`) with a format selection that differs from the one the table was built with, every loaded slot is decoded again from its raw copy, one slot per cycle, before the table is used again.

Top module: `palette_loader`

## Requirements
- R1: The number of entries a load takes follows the depth code captured at `load_start`: code 1 takes 4, code 2 takes 16, code 3 takes 256. Any other code takes none: `done` pulses in the cycle after `load_start`, and `busy` stays low.
- R2: Formats 0 and 1 decode the low half-word as 5:6:5. Red is bits 15:11, green is bits 10:5 and blue is bits 4:0. Each field is placed at the top of its 8-bit output and the unused low bits are zero.
- R3: Format 2 decodes as follows. Red is bits 23:19, green is bits 15:10 and blue is bits 7:3. Each field is placed at the top of its 8-bit output and zero-filled below.
- R4: Format 3 passes the channels through unchanged: red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R5: `lk_data` is laid out as transparency in bit 24, red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Format 0 always gives transparency 0. Formats 1, 2 and 3 copy entry bit 24.
- R6: With the monochrome flag set, red, green and blue all equal entry bits 7:0 in every format. Transparency still follows R5.
- R7: A `frame_start` while idle, with `fmt_sel` different from the format in use, re-decodes all loaded entries with the new format. `busy` stays high for exactly as many cycles as there are loaded entries. A `frame_start` with an unchanged format does nothing.
- R8: A lookup result appears on `lk_data` one cycle after `lk_idx` is presented. Slots never written since the last `load_start` read as zero, and every load first empties the whole table.
- R9: The following are ignored and change neither the table nor the sequence in progress: `ent_valid` while not loading; `load_start` or `frame_start` while busy; and changes of `fmt_sel`, `mono_en` or `depth_code` during a load.
- R10: `busy` rises in the cycle after a `load_start` that takes entries and stays high through any idle gaps in the stream. `done` is a single-cycle pulse in the cycle after the last entry is accepted, and `busy` is low in that cycle.
- R11: After reset, `busy`, `done` and `lk_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start | input | 1 | Begin a palette load (sampled when idle) |
| depth_code | input | 4 | Pixel-depth code: 1, 2 or 3 for 2, 4 or 8 bits per pixel |
| fmt_sel | input | 2 | Entry format 0..3 |
| mono_en | input | 1 | Monochrome decode override |
| ent_valid | input | 1 | Raw entry present on `ent_data` |
| ent_data | input | 32 | Raw palette entry |
| frame_start | input | 1 | Frame boundary; triggers a re-decode on a format change |
| lk_idx | input | IDX_W | Lookup index |
| lk_data | output | 25 | Decoded entry: transparency, red, green, blue |
| busy | output | 1 | Load or re-decode in progress |
| done | output | 1 | Single-cycle pulse at the end of a load |

## Verification
A wrong entry counter shows up on `done` and `busy`. The pulse comes early or late against the count of accepted words, and this is visible in the very cycle the last word is taken. A stale or lost validity bit, or a slot written at the wrong index, shows up on `lk_data` one cycle after that index is looked up. Zeros appear where data is expected, or data where zeros are expected. A format register that follows `fmt_sel` at the wrong time gives wrongly decoded channels on the following lookups. It also shows as a `busy` window after `frame_start` whose length differs from the number of loaded entries.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int RAW_W = 32;

  typedef enum logic [1:0] {
    FMT_565  = 2'd0,
    FMT_565T = 2'd1,
    FMT_666T = 2'd2,
    FMT_888T = 2'd3
  } pal_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SWEEP = 2'd2
  } ctl_state_e;

  typedef struct packed {
    logic       transp;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pal_rgbt_t;

  localparam int OUT_W = $bits(pal_rgbt_t);

  // entries fetched for a pixel-depth code; zero means no palette
  function automatic int unsigned entry_count(input logic [3:0] depth);
    case (depth)
      4'd1:    return 4;
      4'd2:    return 16;
      4'd3:    return 256;
      default: return 0;
    endcase
  endfunction

  // decode one raw entry; fields left-aligned, zero below
  function automatic pal_rgbt_t conv_entry(input logic [RAW_W-1:0] d,
                                           input pal_fmt_e fmt,
                                           input logic mono);
    pal_rgbt_t o;
    o.transp = (fmt != FMT_565) && d[24];
    case (fmt)
      FMT_666T: begin
        o.r = {d[23:19], 3'b000};
        o.g = {d[15:10], 2'b00};
        o.b = {d[7:3],   3'b000};
      end
      FMT_888T: begin
        o.r = d[23:16];
        o.g = d[15:8];
        o.b = d[7:0];
      end
      default: begin
        o.r = {d[15:11], 3'b000};
        o.g = {d[10:5],  2'b00};
        o.b = {d[4:0],   3'b000};
      end
    endcase
    if (mono) begin
      o.r = d[7:0];
      o.g = d[7:0];
      o.b = d[7:0];
    end
    return o;
  endfunction
endpackage

// File: rtl/pal_entry_conv.sv
module pal_entry_conv
  import pal_pkg::*;
(
  input  logic [RAW_W-1:0] raw,
  input  pal_fmt_e         fmt,
  input  logic             mono,
  output pal_rgbt_t        rgbt
);
  assign rgbt = conv_entry(raw, fmt, mono);
endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic             frame_start,
  input  logic             ent_valid,
  input  logic [3:0]       depth_code,
  input  pal_fmt_e         fmt_cfg,
  input  logic             mono_cfg,
  output logic             busy,
  output logic             done,
  output logic             clr_valid,
  output logic             wr_en,
  output logic             raw_wr_en,
  output logic             sel_sweep,
  output logic [IDX_W-1:0] wr_idx,
  output pal_fmt_e         cur_fmt,
  output logic             cur_mono
);
  localparam int CNT_W = IDX_W + 1;

  ctl_state_e       state;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] loaded;
  logic [CNT_W-1:0] idx_nxt;
  logic [CNT_W-1:0] req_cnt;
  logic             fmt_change;

  assign req_cnt    = CNT_W'(entry_count(depth_code));
  assign idx_nxt    = idx + 1'b1;
  assign fmt_change = frame_start && (fmt_cfg != cur_fmt);
  assign busy       = (state != ST_IDLE);
  assign clr_valid  = (state == ST_IDLE) && load_start;
  assign raw_wr_en  = (state == ST_LOAD) && ent_valid;
  assign sel_sweep  = (state == ST_SWEEP);
  assign wr_en      = raw_wr_en || sel_sweep;
  assign wr_idx     = idx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      target   <= '0;
      idx      <= '0;
      loaded   <= '0;
      done     <= 1'b0;
      cur_fmt  <= FMT_565;
      cur_mono <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (load_start) begin
            cur_fmt  <= fmt_cfg;
            cur_mono <= mono_cfg;
            target   <= req_cnt;
            loaded   <= '0;
            idx      <= '0;
            if (req_cnt == '0) done  <= 1'b1;
            else               state <= ST_LOAD;
          end else if (fmt_change) begin
            cur_fmt <= fmt_cfg;
            idx     <= '0;
            if (loaded != '0) state <= ST_SWEEP;
          end
        end
        ST_LOAD: begin
          if (ent_valid) begin
            idx    <= idx_nxt;
            loaded <= idx_nxt;
            if (idx_nxt == target) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        ST_SWEEP: begin
          idx <= idx_nxt;
          if (idx_nxt == loaded) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_valid,
  input  logic             wr_en,
  input  logic             raw_wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RAW_W-1:0] raw_in,
  input  pal_rgbt_t        conv_in,
  output logic [RAW_W-1:0] raw_rd,
  input  logic [IDX_W-1:0] lk_idx,
  output pal_rgbt_t        lk_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [RAW_W-1:0] raw_mem  [DEPTH];
  pal_rgbt_t        conv_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (raw_wr_en) raw_mem[wr_idx] <= raw_in;
  end

  always_ff @(posedge clk) begin
    if (wr_en) conv_mem[wr_idx] <= conv_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          valid_q <= '0;
    else if (clr_valid)  valid_q <= '0;
    else if (raw_wr_en)  valid_q[wr_idx] <= 1'b1;
  end

  assign raw_rd = raw_mem[wr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lk_data <= '0;
    else if (valid_q[lk_idx]) lk_data <= conv_mem[lk_idx];
    else                      lk_data <= '0;
  end
endmodule

// File: rtl/palette_loader.sv
module palette_loader
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic [3:0]       depth_code,
  input  logic [1:0]       fmt_sel,
  input  logic             mono_en,
  input  logic             ent_valid,
  input  logic [RAW_W-1:0] ent_data,
  input  logic             frame_start,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [OUT_W-1:0] lk_data,
  output logic             busy,
  output logic             done
);
  logic             clr_valid;
  logic             wr_en;
  logic             raw_wr_en;
  logic             sel_sweep;
  logic [IDX_W-1:0] wr_idx;
  pal_fmt_e         cur_fmt;
  logic             cur_mono;
  logic [RAW_W-1:0] raw_rd;
  logic [RAW_W-1:0] conv_src;
  pal_rgbt_t        conv_out;
  pal_rgbt_t        lk_q;

  pal_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_start  (load_start),
    .frame_start (frame_start),
    .ent_valid   (ent_valid),
    .depth_code  (depth_code),
    .fmt_cfg     (pal_fmt_e'(fmt_sel)),
    .mono_cfg    (mono_en),
    .busy        (busy),
    .done        (done),
    .clr_valid   (clr_valid),
    .wr_en       (wr_en),
    .raw_wr_en   (raw_wr_en),
    .sel_sweep   (sel_sweep),
    .wr_idx      (wr_idx),
    .cur_fmt     (cur_fmt),
    .cur_mono    (cur_mono)
  );

  // a sweep re-decodes the stored raw word, a load decodes the stream
  assign conv_src = sel_sweep ? raw_rd : ent_data;

  pal_entry_conv u_conv (
    .raw  (conv_src),
    .fmt  (cur_fmt),
    .mono (cur_mono),
    .rgbt (conv_out)
  );

  pal_store #(.IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_valid (clr_valid),
    .wr_en     (wr_en),
    .raw_wr_en (raw_wr_en),
    .wr_idx    (wr_idx),
    .raw_in    (ent_data),
    .conv_in   (conv_out),
    .raw_rd    (raw_rd),
    .lk_idx    (lk_idx),
    .lk_data   (lk_q)
  );

  assign lk_data = lk_q;
endmodule

// File: rtl/pal_checker.sv
module pal_checker
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_start,
  input logic             frame_start,
  input logic [1:0]       fmt_sel,
  input logic [3:0]       depth_code,
  input logic             busy,
  input logic             done,
  input logic             clr_valid,
  input logic             wr_en,
  input logic             raw_wr_en,
  input logic [1:0]       cur_fmt,
  input logic [OUT_W-1:0] conv_out,
  input logic [OUT_W-1:0] lk_data
);
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] wcount;
  logic [CNT_W-1:0] exp_cnt;
  logic             ever_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcount  <= '0;
      exp_cnt <= '0;
      ever_wr <= 1'b0;
    end else begin
      if (wr_en) ever_wr <= 1'b1;
      if (clr_valid) begin
        wcount  <= '0;
        exp_cnt <= CNT_W'(entry_count(depth_code));
      end else if (raw_wr_en) begin
        wcount <= wcount + 1'b1;
      end
    end
  end

  // R1: a load ends after exactly the depth-selected number of words
  a_r1_entry_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wcount == exp_cnt));

  // R10: done lasts one cycle and coincides with idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: nothing is written while idle
  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

  // R5: format 0 never yields transparency
  a_r5_fmt0_opaque: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_fmt == 2'd0) |-> !conv_out[24]);

  // R7: an idle frame boundary adopts the selected format
  a_r7_fmt_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load_start && frame_start) |=> (cur_fmt == $past(fmt_sel)));

  // R8: nothing but zero is looked up before any slot is written
  a_r8_blank_until_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ever_wr |-> (lk_data == '0));
endmodule

bind palette_loader pal_checker #(.IDX_W(IDX_W)) u_pal_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_start  (load_start),
  .frame_start (frame_start),
  .fmt_sel     (fmt_sel),
  .depth_code  (depth_code),
  .busy        (busy),
  .done        (done),
  .clr_valid   (clr_valid),
  .wr_en       (wr_en),
  .raw_wr_en   (raw_wr_en),
  .cur_fmt     (cur_fmt),
  .conv_out    (conv_out),
  .lk_data     (lk_data)
);

// File: tb/palette_loader_bench.sv
module palette_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_start = 1'b0;
  logic [3:0]  depth_code = '0;
  logic [1:0]  fmt_sel = '0;
  logic        mono_en = 1'b0;
  logic        ent_valid = 1'b0;
  logic [31:0] ent_data = '0;
  logic        frame_start = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic [24:0] lk_data;
  logic        busy;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_raw [256];
  bit          m_val [256];
  int          m_fmt  = 0;
  bit          m_mono = 1'b0;
  int          m_cnt  = 0;

  always #2.5 clk = ~clk;

  palette_loader u_palette_loader (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .depth_code(depth_code),
    .fmt_sel(fmt_sel), .mono_en(mono_en), .ent_valid(ent_valid), .ent_data(ent_data),
    .frame_start(frame_start), .lk_idx(lk_idx), .lk_data(lk_data),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int i, input int seed);
    return (32'(i) * 32'h9E3779B1) ^ (32'(seed) * 32'h85EBCA6B) ^ 32'(seed);
  endfunction

  function automatic int count_for(input logic [3:0] dc);
    return (dc == 4'd1) ? 4 : (dc == 4'd2) ? 16 : (dc == 4'd3) ? 256 : 0;
  endfunction

  // independent reference decoder built from masks and shifts
  function automatic logic [24:0] ref_out(input logic [31:0] w, input int fmt, input bit mono);
    logic [7:0] r, g, b;
    logic t;
    if (fmt == 3) begin
      r = 8'(w >> 16); g = 8'(w >> 8); b = 8'(w);
    end else if (fmt == 2) begin
      r = 8'((w >> 16) & 32'hF8); g = 8'((w >> 8) & 32'hFC); b = 8'(w & 32'hF8);
    end else begin
      r = 8'((w >> 8) & 32'hF8); g = 8'((w >> 3) & 32'hFC); b = 8'((w << 3) & 32'hF8);
    end
    if (mono) begin
      r = 8'(w); g = 8'(w); b = 8'(w);
    end
    t = (fmt != 0) ? w[24] : 1'b0;
    return {t, r, g, b};
  endfunction

  task automatic check_table(input string req, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      logic [24:0] e;
      @(negedge clk);
      lk_idx = 8'(i);
      @(negedge clk);
      e = m_val[i] ? ref_out(m_raw[i], m_fmt, m_mono) : 25'd0;
      chk(req, 32'(lk_data), 32'(e));
    end
  endtask

  task automatic do_load(input logic [3:0] dc, input int fmt, input bit mono,
                         input int seed, input bit gaps);
    int n;
    n = count_for(dc);
    @(negedge clk);
    load_start = 1'b1; depth_code = dc; fmt_sel = 2'(fmt); mono_en = mono;
    @(negedge clk);
    load_start = 1'b0;
    for (int i = 0; i < 256; i++) m_val[i] = 1'b0;
    m_fmt = fmt; m_mono = mono; m_cnt = n;
    if (n == 0) begin
      chk("R1 empty load done", 32'(done), 32'd1);
      chk("R1 empty load busy", 32'(busy), 32'd0);
      @(negedge clk);
      chk("R10 done pulse", 32'(done), 32'd0);
      return;
    end
    chk("R10 busy after start", 32'(busy), 32'd1);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        ent_valid = 1'b0;
        @(negedge clk);
        chk("R10 busy in gap", 32'(busy), 32'd1);
      end
      ent_valid = 1'b1;
      ent_data  = gen(i, seed);
      m_raw[i]  = ent_data;
      m_val[i]  = 1'b1;
      @(negedge clk);
      if (i == n - 2) chk("R10 no early done", 32'(done), 32'd0);
    end
    ent_valid = 1'b0;
    chk("R10 done after last", 32'(done), 32'd1);
    chk("R10 idle at done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R10 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic do_frame(input int new_fmt, input int exp_cycles, input string req);
    int cyc;
    @(negedge clk);
    fmt_sel = 2'(new_fmt); frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    chk(req, 32'(cyc), 32'(exp_cycles));
    m_fmt = new_fmt;
  endtask

  task automatic t_reset;
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 lk_data", 32'(lk_data), 32'd0);
    check_table("R8 unloaded after reset", 0, 3);
  endtask

  task automatic t_fmt0;
    do_load(4'd1, 0, 1'b0, 11, 1'b0);
    check_table("R2 R5 fmt0 decode", 0, 3);
    check_table("R1 R8 beyond 4 entries", 4, 6);
  endtask

  task automatic t_fmt1;
    do_load(4'd2, 1, 1'b0, 22, 1'b1);
    check_table("R2 R5 fmt1 decode", 0, 15);
    check_table("R1 R8 beyond 16 entries", 16, 18);
  endtask

  task automatic t_fmt2_full;
    do_load(4'd3, 2, 1'b0, 33, 1'b0);
    check_table("R3 R5 fmt2 decode full table", 0, 255);
  endtask

  task automatic t_fmt3;
    do_load(4'd2, 3, 1'b0, 44, 1'b0);
    check_table("R4 R5 fmt3 decode", 0, 15);
  endtask

  task automatic t_mono;
    do_load(4'd2, 3, 1'b1, 55, 1'b0);
    check_table("R6 mono fmt3", 0, 15);
    do_load(4'd1, 0, 1'b1, 66, 1'b0);
    check_table("R6 mono fmt0", 0, 3);
  endtask

  task automatic t_no_palette;
    do_load(4'd4, 3, 1'b0, 77, 1'b0);
    check_table("R1 R8 depth 4 empties table", 0, 3);
    do_load(4'd0, 1, 1'b0, 78, 1'b0);
    check_table("R1 R8 depth 0 empties table", 0, 1);
  endtask

  task automatic t_reconvert;
    do_load(4'd2, 3, 1'b0, 88, 1'b0);
    do_frame(0, 16, "R7 sweep length fmt3 to fmt0");
    check_table("R7 re-decoded as fmt0", 0, 15);
    do_frame(2, 16, "R7 sweep length fmt0 to fmt2");
    check_table("R7 re-decoded as fmt2", 0, 15);
    do_frame(2, 0, "R7 no sweep on same format");
    check_table("R7 unchanged table", 0, 3);
  endtask

  task automatic t_ignore;
    // stray stream words while idle
    @(negedge clk);
    ent_valid = 1'b1; ent_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    ent_valid = 1'b0;
    chk("R9 idle stream no busy", 32'(busy), 32'd0);
    check_table("R9 idle stream ignored", 0, 15);
    // load of 16 with disturbances mid-way
    @(negedge clk);
    load_start = 1'b1; depth_code = 4'd2; fmt_sel = 2'd1; mono_en = 1'b0;
    @(negedge clk);
    load_start = 1'b0;
    for (int i = 0; i < 256; i++) m_val[i] = 1'b0;
    m_fmt = 1; m_mono = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ent_valid = 1'b1;
      ent_data  = gen(i, 99);
      m_raw[i]  = ent_data;
      m_val[i]  = 1'b1;
      if (i == 5) begin
        load_start = 1'b1; depth_code = 4'd3; fmt_sel = 2'd3; mono_en = 1'b1;
      end
      if (i == 6) begin
        load_start = 1'b0; frame_start = 1'b1;
      end
      if (i == 7) frame_start = 1'b0;
      @(negedge clk);
    end
    ent_valid = 1'b0;
    chk("R9 load_start during load ignored", 32'(done), 32'd1);
    check_table("R9 config change mid-load ignored", 0, 17);
    fmt_sel = 2'd1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fmt0();
    t_fmt1();
    t_fmt2_full();
    t_fmt3();
    t_mono();
    t_no_palette();
    t_reconvert();
    t_ignore();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule